// File: doc/BRIEF.md
# Parallel Self-Synchronizing Scrambler with NRZI Line Coding

This block conditions a stream of 10-bit video characters for a serial link. One character is accepted each clock. Its bits are passed through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1. The ten serial steps are unrolled into combinational logic, so a whole character is handled in one cycle. The scrambled bits then go through an NRZ-to-NRZI converter. After that conversion the line has dense transitions and does not care about polarity. Both the scrambler history and the NRZI level carry from one character to the next, exactly as a bit-serial encoder would.

A registered raw-path select lets a character skip both coding stages and go straight to the output register. A packet-transport mode select forces the raw path whatever the raw-path select says. On raw cycles the coding state is frozen. Encoding then resumes as if the raw characters had never been sent. The block feeds a serializer that sends bit 0 of each word first.

Top module: `sync_scrambler_nrzi`

## Requirements
- R1: While reset is asserted and after it is released, the output word is zero. The scrambler history and the NRZI level both start from all zeros.
- R2: In coded mode each bit is scrambled in transmit order, bit 0 first. The scrambled bit equals the input bit XOR the scrambled bit sent 4 bit-times earlier XOR the scrambled bit sent 9 bit-times earlier.
- R3: Each scrambled bit, taken in transmit order, is NRZI coded. The coded bit equals the scrambled bit XOR the coded bit sent just before it.
- R4: When the raw-path select is 1 and packet mode is 0, the output word equals the input character unchanged.
- R5: When packet mode is 1, the raw-path select has no effect and the output word equals the input character.
- R6: On raw-path and packet-mode cycles, neither the scrambler history nor the NRZI level advances. The next coded character continues from the state left by the last coded character.
- R7: A character presented before clock edge k appears on the output word after clock edge k+1. There is one input register and one output register.
- R8: The scrambler history and the NRZI level cross character boundaries. Bit 0 of a character uses the last bits of the previous coded character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chr_i | input | 10 | Input character, bit 0 transmitted first |
| raw_i | input | 1 | Raw-path select, 1 skips scrambler and NRZI |
| pkt_mode_i | input | 1 | Packet-transport mode, 1 forces the raw path |
| word_o | output | 10 | Registered output word |

## Verification
The assertions assume that the mode and raw-path inputs are stable across each clock edge and never X. They also assume that reset is released away from an edge. The stimulus changes every input only on the falling clock edge, so each registered select is well defined. The state-hold and state-link properties take the raw/coded decision from the registered selects. The bench therefore mixes raw, packet-mode and coded characters back to back, covering both raw-select values in packet mode, so every transition between paths is seen.

// File: rtl/scr_nrzi_pkg.sv
package scr_nrzi_pkg;

   localparam int CHR_W_DEF    = 10;
   localparam int LFSR_LEN_DEF = 9;
   localparam int LFSR_TAP_DEF = 4;

   // Maps transmit step n to the word bit sent at that step.
   function automatic int tx_pos(input int n, input int w, input bit lsb_first);
      return lsb_first ? n : (w - 1 - n);
   endfunction

endpackage

// File: rtl/scr_in_reg.sv
module scr_in_reg #(
   parameter int W = scr_nrzi_pkg::CHR_W_DEF
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] chr_i,
   input  logic         raw_i,
   input  logic         pkt_i,
   output logic [W-1:0] chr_q_o,
   output logic         raw_q_o,
   output logic         pkt_q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chr_q_o <= '0;
         raw_q_o <= 1'b0;
         pkt_q_o <= 1'b0;
      end else begin
         chr_q_o <= chr_i;
         raw_q_o <= raw_i;
         pkt_q_o <= pkt_i;
      end
   end

endmodule

// File: rtl/scr_lfsr_par.sv
module scr_lfsr_par
   import scr_nrzi_pkg::*;
#(
   parameter int W         = CHR_W_DEF,
   parameter int LEN       = LFSR_LEN_DEF,
   parameter int TAP       = LFSR_TAP_DEF,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         adv_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);

   localparam int EXT_W = LEN + W;
   localparam int LAST  = tx_pos(W - 1, W, LSB_FIRST);

   if (W < 1) begin : g_bad_w
      $error("scr_lfsr_par: W must be at least 1");
   end
   if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
      $error("scr_lfsr_par: TAP must lie in 1..LEN-1");
   end

   // hist_q[k-1] holds the scrambled bit sent k bit-times ago
   logic [LEN-1:0] hist_q;
   logic [LEN-1:0] hist_d;

   // ext[LEN-k] is history k bits back, ext[LEN+i] is step i of this character
   always_comb begin
      logic [EXT_W-1:0] ext;
      ext = '0;
      for (int k = 1; k <= LEN; k++) begin
         ext[LEN-k] = hist_q[k-1];
      end
      for (int i = 0; i < W; i++) begin
         ext[LEN+i] = din_i[tx_pos(i, W, LSB_FIRST)] ^ ext[LEN+i-TAP] ^ ext[i];
      end
      for (int i = 0; i < W; i++) begin
         dout_o[tx_pos(i, W, LSB_FIRST)] = ext[LEN+i];
      end
      for (int k = 1; k <= LEN; k++) begin
         hist_d[k-1] = ext[EXT_W-k];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q <= '0;
      end else if (adv_i) begin
         hist_q <= hist_d;
      end
   end

   // R6: history frozen on raw cycles
   p_hist_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(hist_q))
      else $error("p_hist_hold_r6");

   // R8: newest history bit is the last bit sent of the previous coded character
   p_hist_link_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i |=> hist_q[0] == $past(dout_o[LAST]))
      else $error("p_hist_link_r8");

endmodule

// File: rtl/scr_nrzi_stage.sv
module scr_nrzi_stage
   import scr_nrzi_pkg::*;
#(
   parameter int W         = CHR_W_DEF,
   parameter bit LSB_FIRST = 1'b1,
   parameter bit NRZI_EN   = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         adv_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);

   localparam int LAST = tx_pos(W - 1, W, LSB_FIRST);

   if (NRZI_EN) begin : g_nrzi
      logic lvl_q;
      logic lvl_d;

      always_comb begin
         logic run;
         run = lvl_q;
         for (int i = 0; i < W; i++) begin
            run = run ^ din_i[tx_pos(i, W, LSB_FIRST)];
            dout_o[tx_pos(i, W, LSB_FIRST)] = run;
         end
         lvl_d = run;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            lvl_q <= 1'b0;
         end else if (adv_i) begin
            lvl_q <= lvl_d;
         end
      end

      // R3: line level seeding the next character is the last coded bit
      p_lvl_seed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         adv_i |=> lvl_q == $past(dout_o[LAST]))
         else $error("p_lvl_seed_r3");

      // R6: line level frozen on raw cycles
      p_lvl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !adv_i |=> $stable(lvl_q))
         else $error("p_lvl_hold_r6");
   end else begin : g_plain
      logic unused_ok;
      assign unused_ok = clk_i ^ rst_ni ^ adv_i;
      assign dout_o    = din_i;
   end

endmodule

// File: rtl/sync_scrambler_nrzi.sv
module sync_scrambler_nrzi
   import scr_nrzi_pkg::*;
#(
   parameter int W         = CHR_W_DEF,
   parameter int LEN       = LFSR_LEN_DEF,
   parameter int TAP       = LFSR_TAP_DEF,
   parameter bit LSB_FIRST = 1'b1,
   parameter bit NRZI_EN   = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] chr_i,
   input  logic         raw_i,
   input  logic         pkt_mode_i,
   output logic [W-1:0] word_o
);

   logic [W-1:0] chr_q;
   logic         raw_q;
   logic         pkt_q;
   logic         take_raw;
   logic         adv;
   logic [W-1:0] scr_w;
   logic [W-1:0] enc_w;
   logic [W-1:0] word_d;
   logic [W-1:0] word_q;

   scr_in_reg #(.W(W)) in_reg_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .chr_i   (chr_i),
      .raw_i   (raw_i),
      .pkt_i   (pkt_mode_i),
      .chr_q_o (chr_q),
      .raw_q_o (raw_q),
      .pkt_q_o (pkt_q)
   );

   // packet mode overrides the raw select
   assign take_raw = pkt_q | raw_q;
   assign adv      = ~take_raw;

   scr_lfsr_par #(.W(W), .LEN(LEN), .TAP(TAP), .LSB_FIRST(LSB_FIRST)) scr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv),
      .din_i  (chr_q),
      .dout_o (scr_w)
   );

   scr_nrzi_stage #(.W(W), .LSB_FIRST(LSB_FIRST), .NRZI_EN(NRZI_EN)) nrzi_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv),
      .din_i  (scr_w),
      .dout_o (enc_w)
   );

   assign word_d = take_raw ? chr_q : enc_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
      end else begin
         word_q <= word_d;
      end
   end

   assign word_o = word_q;

   // R4: raw select without packet mode copies the registered character
   p_raw_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_q && !pkt_q) |=> word_q == $past(chr_q))
      else $error("p_raw_copy_r4");

   // R5: packet mode always copies, raw select irrelevant
   p_pkt_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_q |=> word_q == $past(chr_q))
      else $error("p_pkt_copy_r5");

endmodule

// File: tb/sync_scrambler_nrzi_tb.sv
module sync_scrambler_nrzi_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] chr = '0;
   logic       raw = 1'b0;
   logic       pkt = 1'b0;
   logic [9:0] word;

   always #10 clk = ~clk;

   sync_scrambler_nrzi dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .chr_i      (chr),
      .raw_i      (raw),
      .pkt_mode_i (pkt),
      .word_o     (word)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // bit-serial model state: m_sh[0] is the most recent scrambled bit
   logic [8:0] m_sh = '0;
   logic       m_lvl = 1'b0;

   logic [9:0] pend_v [2];
   bit         pend_ok [2];
   string      pend_tag [2];

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic model_enc(input logic [9:0] d, output logic [9:0] e);
      for (int i = 0; i < 10; i++) begin
         logic s;
         s     = d[i] ^ m_sh[3] ^ m_sh[8];
         m_sh  = {m_sh[7:0], s};
         m_lvl = m_lvl ^ s;
         e[i]  = m_lvl;
      end
   endtask

   // one character per falling edge; checks the one driven two edges back (R7)
   task automatic step(input logic [9:0] d, input logic r, input logic p, input string tag);
      logic [9:0] e;
      @(negedge clk);
      if (pend_ok[1]) check({pend_tag[1], " R7"}, word, pend_v[1]);
      pend_v[1]   = pend_v[0];
      pend_ok[1]  = pend_ok[0];
      pend_tag[1] = pend_tag[0];
      chr = d;
      raw = r;
      pkt = p;
      if (r || p) e = d;
      else model_enc(d, e);
      pend_v[0]   = e;
      pend_ok[0]  = 1'b1;
      pend_tag[0] = tag;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: act=running exp=finished");
      finish_run();
   end

   initial begin
      bit prev_raw;
      pend_ok[0] = 1'b0;
      pend_ok[1] = 1'b0;
      chr = 10'h3A5;
      raw = 1'b0;
      pkt = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset word", word, 10'h000);
      @(negedge clk);
      rst_n = 1'b1;
      chr   = 10'h000;
      @(negedge clk);
      check("R1 word after release", word, 10'h000);

      // first character encoded from all-zero state
      step(10'h001, 1'b0, 1'b0, "R1 R2 R3 zero-state");
      // exhaustive sweep of coded characters, state crossing each boundary
      for (int v = 0; v < 1024; v++) begin
         step(v[9:0], 1'b0, 1'b0, "R2 R3 R8 sweep");
      end
      // fixed raw and packet-mode patterns
      step(10'h3FF, 1'b1, 1'b0, "R4 raw");
      step(10'h000, 1'b1, 1'b0, "R4 raw");
      step(10'h2AA, 1'b0, 1'b1, "R5 pkt raw0");
      step(10'h155, 1'b1, 1'b1, "R5 pkt raw1");
      step(10'h3FC, 1'b0, 1'b0, "R6 resume");
      step(10'h003, 1'b0, 1'b0, "R6 resume");
      // random mixture of paths
      prev_raw = 1'b0;
      for (int n = 0; n < 2000; n++) begin
         logic [9:0] d;
         logic       r;
         logic       p;
         d = 10'($urandom);
         r = ($urandom % 4) == 0;
         p = ($urandom % 8) == 0;
         if (p)             step(d, r, p, "R5 pkt");
         else if (r)        step(d, r, p, "R4 raw");
         else if (prev_raw) step(d, r, p, "R6 resume");
         else               step(d, r, p, "R2 R3 R8 random");
         prev_raw = r | p;
      end
      // flush the pipeline
      step(10'h000, 1'b1, 1'b0, "R4 flush");
      step(10'h000, 1'b1, 1'b0, "R4 flush");
      step(10'h000, 1'b1, 1'b0, "R4 flush");
      finish_run();
   end

endmodule